// File: doc/BRIEF.md
# Single-Beat PCI Access Engine

This block lets a host processor run one-data-phase PCI transactions (configuration, memory and I/O) through a small set of registers. Software stores a bus address, optionally stores write data, and then writes the command/byte-enable register. That command write is the trigger: the engine copies the stored fields into a request for a PCI master sequencer and holds the request until the sequencer acknowledges it. For reads, the returned word (or all ones after a master abort) lands in the read-data register.

While a read is in flight, every host read of any engine register is answered with a retry instead of data. Software therefore cannot see the read-data register before it holds the new word. A status word reports a busy flag and two sticky flags. One flag records a command write that arrived while busy and was dropped. The other records a master abort. Both clear by writing 1 to them.

The sequencer has three states. SEQ_IDLE waits for a launch. SEQ_REQ drives the bus request. SEQ_FILL spends one cycle storing read data. The transitions are: IDLE→REQ on a command write while idle; REQ→FILL on acknowledge of a read; REQ→IDLE on acknowledge of a write; FILL→IDLE unconditionally.

Top module: `npacc_engine`

## Requirements
- R1: Host word offsets are 0 address, 1 command, 2 write data, 3 read data and 4 status. Address and write data read back as last written. Host writes to offset 3 are ignored. Unmapped offsets read zero.
- R2: The command register holds the bus command in bits [3:0] and the active-low byte enables in bits [7:4]. Bits [31:8] always read zero.
- R3: A command write while idle raises bus_req on the next cycle. The request carries the stored address, the written command and byte enables, and the stored write data.
- R4: bus_req stays high, with bus_addr, bus_cmd, bus_be_n and bus_wdata stable, until bus_ack is sampled. It is low in the cycle after the acknowledge.
- R5: Command bit 0 selects the direction: 0 is a read and 1 is a write. I/O (0010/0011), memory (0110/0111) and configuration (1010/1011) commands are all issued. After a read acknowledge, bus_rdata is stored in the read-data register.
- R6: A host read sampled between a read launch and the cycle that stores its data (the SEQ_REQ and SEQ_FILL cycles of a read) gets hst_rd_retry and no hst_rd_valid. hst_rd_valid and hst_rd_retry are never both high.
- R7: During a write transaction, host reads are answered with data (hst_rd_valid) and not retried.
- R8: Status bit 0 is 1 from the cycle after launch until the transaction completes.
- R9: A command write while busy is ignored: the bus fields and the command register keep their values. It sets sticky status bit 1, which a host write of 1 to that bit clears.
- R10: A master abort sets sticky status bit 2, which a write of 1 clears. On a read, the abort loads the read-data register with all ones. On a write, it leaves the read-data register unchanged.
- R11: The bus address is the stored address unmodified. Type 0 configuration layout: [1:0]=00, [7:2] register, [10:8] function. Type 1 layout: [1:0]=01, [7:2] register, [10:8] function, [15:11] device, [23:16] bus.
- R12: After reset, all registers read zero and bus_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_wr_en | input | 1 | Host register write strobe |
| hst_rd_en | input | 1 | Host register read strobe |
| hst_addr | input | 3 | Host register word offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Read response data, valid with hst_rd_valid |
| hst_rd_valid | output | 1 | Read answered with data (cycle after strobe) |
| hst_rd_retry | output | 1 | Read must be retried (cycle after strobe) |
| bus_req | output | 1 | Single-beat request to the PCI master sequencer |
| bus_addr | output | 32 | Transaction address |
| bus_cmd | output | 4 | PCI bus command |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction finished |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_mabort | input | 1 | Master abort status, valid with bus_ack |

## Verification
Directed sequences compare a Type 1 configuration read with a Type 0 configuration write. This separates the read-data capture and its retry window from the write path, which never stalls host reads. It also shows whether address fields reach the bus bit for bit. A command write issued mid-write and aborts on both a read and a write distinguish the three sticky or ignore behaviours from each other. Random rounds mix I/O, memory and configuration commands, random byte enables and acknowledge latencies of zero to three cycles. A misplaced direction bit, a retry window that is too short or too long, or a request dropped early then shows up as a wrong bus field, a missing retry or stale read data.

// File: rtl/npacc_pkg.sv
package npacc_pkg;

    localparam int CMD_W   = 4;
    localparam int BE_W    = 4;
    localparam int HADDR_W = 3;

    localparam logic [HADDR_W-1:0] OFS_ADDR  = 3'd0;
    localparam logic [HADDR_W-1:0] OFS_CMD   = 3'd1;
    localparam logic [HADDR_W-1:0] OFS_WDATA = 3'd2;
    localparam logic [HADDR_W-1:0] OFS_RDATA = 3'd3;
    localparam logic [HADDR_W-1:0] OFS_STAT  = 3'd4;

    localparam int ST_BUSY  = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_ABORT = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_FILL = 2'd2
    } seq_state_e;

    // Bus command bit 0 clear means a read-type command.
    function automatic logic cmd_is_read(input logic [CMD_W-1:0] cmd);
        return ~cmd[0];
    endfunction

endpackage

// File: rtl/npacc_regs.sv
module npacc_regs
    import npacc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hst_wr_en,
    input  logic                 hst_rd_en,
    input  logic [HADDR_W-1:0]   hst_addr,
    input  logic [DATA_W-1:0]    hst_wdata,
    output logic [DATA_W-1:0]    hst_rdata,
    output logic                 hst_rd_valid,
    output logic                 hst_rd_retry,
    input  logic                 seq_busy,
    input  logic                 seq_rd_pend,
    input  logic                 cap_load,
    input  logic [DATA_W-1:0]    cap_data,
    input  logic                 abort_evt,
    output logic                 launch,
    output logic [CMD_W-1:0]     launch_cmd,
    output logic [BE_W-1:0]      launch_be_n,
    output logic [DATA_W-1:0]    addr_q,
    output logic [DATA_W-1:0]    wdata_q,
    output logic                 abort_sticky
);

    localparam int CMDF_W = CMD_W + BE_W;

    logic [CMD_W-1:0]  cmd_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_sticky;
    logic              cmd_wr;
    logic              overlap;
    logic              stat_wr;
    logic [DATA_W-1:0] rd_word;

    assign cmd_wr      = hst_wr_en && (hst_addr == OFS_CMD);
    assign stat_wr     = hst_wr_en && (hst_addr == OFS_STAT);
    assign launch      = cmd_wr && !seq_busy;
    assign overlap     = cmd_wr && seq_busy;
    assign launch_cmd  = hst_wdata[CMD_W-1:0];
    assign launch_be_n = hst_wdata[CMDF_W-1:CMD_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            cmd_q   <= '0;
            be_q    <= '0;
        end else begin
            if (hst_wr_en && (hst_addr == OFS_ADDR))  addr_q  <= hst_wdata;
            if (hst_wr_en && (hst_addr == OFS_WDATA)) wdata_q <= hst_wdata;
            if (launch) begin
                cmd_q <= launch_cmd;
                be_q  <= launch_be_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cap_load) begin
            rdata_q <= cap_data;
        end
    end

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_sticky   <= 1'b0;
            abort_sticky <= 1'b0;
        end else begin
            if (overlap)
                err_sticky <= 1'b1;
            else if (stat_wr && hst_wdata[ST_ERR])
                err_sticky <= 1'b0;
            if (abort_evt)
                abort_sticky <= 1'b1;
            else if (stat_wr && hst_wdata[ST_ABORT])
                abort_sticky <= 1'b0;
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (hst_addr)
            OFS_ADDR:  rd_word = addr_q;
            OFS_CMD:   rd_word[CMDF_W-1:0] = {be_q, cmd_q};
            OFS_WDATA: rd_word = wdata_q;
            OFS_RDATA: rd_word = rdata_q;
            OFS_STAT: begin
                rd_word[ST_BUSY]  = seq_busy;
                rd_word[ST_ERR]   = err_sticky;
                rd_word[ST_ABORT] = abort_sticky;
            end
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hst_rd_valid <= 1'b0;
            hst_rd_retry <= 1'b0;
            hst_rdata    <= '0;
        end else begin
            hst_rd_valid <= hst_rd_en && !seq_rd_pend;
            hst_rd_retry <= hst_rd_en && seq_rd_pend;
            hst_rdata    <= (hst_rd_en && !seq_rd_pend) ? rd_word : '0;
        end
    end

endmodule

// File: rtl/npacc_seq.sv
module npacc_seq
    import npacc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic [CMD_W-1:0]     launch_cmd,
    input  logic [BE_W-1:0]      launch_be_n,
    input  logic [DATA_W-1:0]    addr_q,
    input  logic [DATA_W-1:0]    wdata_q,
    input  logic                 bus_ack,
    input  logic [DATA_W-1:0]    bus_rdata,
    input  logic                 bus_mabort,
    output logic                 bus_req,
    output logic [DATA_W-1:0]    bus_addr,
    output logic [CMD_W-1:0]     bus_cmd,
    output logic [BE_W-1:0]      bus_be_n,
    output logic [DATA_W-1:0]    bus_wdata,
    output logic                 busy,
    output logic                 rd_pend,
    output logic                 cap_load,
    output logic [DATA_W-1:0]    cap_data,
    output logic                 abort_evt
);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic              is_rd_q;
    logic [DATA_W-1:0] fill_q;
    logic              ack_seen;

    assign ack_seen = (state_q == SEQ_REQ) && bus_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (launch)   state_d = SEQ_REQ;
            SEQ_REQ:  if (bus_ack)  state_d = is_rd_q ? SEQ_FILL : SEQ_IDLE;
            SEQ_FILL:               state_d = SEQ_IDLE;
            default:                state_d = SEQ_IDLE;
        endcase
    end

    // Launch snapshot keeps the request fields fixed while host registers change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_cmd   <= '0;
            bus_be_n  <= '0;
            bus_wdata <= '0;
            is_rd_q   <= 1'b0;
        end else if (launch && (state_q == SEQ_IDLE)) begin
            bus_addr  <= addr_q;
            bus_cmd   <= launch_cmd;
            bus_be_n  <= launch_be_n;
            bus_wdata <= wdata_q;
            is_rd_q   <= cmd_is_read(launch_cmd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (ack_seen && is_rd_q) begin
            fill_q <= bus_mabort ? '1 : bus_rdata;
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        busy      = 1'b0;
        rd_pend   = 1'b0;
        cap_load  = 1'b0;
        cap_data  = fill_q;
        abort_evt = 1'b0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_REQ: begin
                bus_req   = 1'b1;
                busy      = 1'b1;
                rd_pend   = is_rd_q;
                abort_evt = bus_ack && bus_mabort;
            end
            SEQ_FILL: begin
                busy     = 1'b1;
                rd_pend  = 1'b1;
                cap_load = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/npacc_engine.sv
module npacc_engine
    import npacc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hst_wr_en,
    input  logic                 hst_rd_en,
    input  logic [HADDR_W-1:0]   hst_addr,
    input  logic [DATA_W-1:0]    hst_wdata,
    output logic [DATA_W-1:0]    hst_rdata,
    output logic                 hst_rd_valid,
    output logic                 hst_rd_retry,
    output logic                 bus_req,
    output logic [DATA_W-1:0]    bus_addr,
    output logic [CMD_W-1:0]     bus_cmd,
    output logic [BE_W-1:0]      bus_be_n,
    output logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_ack,
    input  logic [DATA_W-1:0]    bus_rdata,
    input  logic                 bus_mabort
);

    logic              launch_w;
    logic [CMD_W-1:0]  launch_cmd_w;
    logic [BE_W-1:0]   launch_be_w;
    logic [DATA_W-1:0] addr_w;
    logic [DATA_W-1:0] wdata_w;
    logic              busy_w;
    logic              rd_pend_w;
    logic              cap_load_w;
    logic [DATA_W-1:0] cap_data_w;
    logic              abort_evt_w;
    logic              abort_st_w;

    npacc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .hst_wr_en    (hst_wr_en),
        .hst_rd_en    (hst_rd_en),
        .hst_addr     (hst_addr),
        .hst_wdata    (hst_wdata),
        .hst_rdata    (hst_rdata),
        .hst_rd_valid (hst_rd_valid),
        .hst_rd_retry (hst_rd_retry),
        .seq_busy     (busy_w),
        .seq_rd_pend  (rd_pend_w),
        .cap_load     (cap_load_w),
        .cap_data     (cap_data_w),
        .abort_evt    (abort_evt_w),
        .launch       (launch_w),
        .launch_cmd   (launch_cmd_w),
        .launch_be_n  (launch_be_w),
        .addr_q       (addr_w),
        .wdata_q      (wdata_w),
        .abort_sticky (abort_st_w)
    );

    npacc_seq #(.DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch_w),
        .launch_cmd  (launch_cmd_w),
        .launch_be_n (launch_be_w),
        .addr_q      (addr_w),
        .wdata_q     (wdata_w),
        .bus_ack     (bus_ack),
        .bus_rdata   (bus_rdata),
        .bus_mabort  (bus_mabort),
        .bus_req     (bus_req),
        .bus_addr    (bus_addr),
        .bus_cmd     (bus_cmd),
        .bus_be_n    (bus_be_n),
        .bus_wdata   (bus_wdata),
        .busy        (busy_w),
        .rd_pend     (rd_pend_w),
        .cap_load    (cap_load_w),
        .cap_data    (cap_data_w),
        .abort_evt   (abort_evt_w)
    );

endmodule

// File: rtl/npacc_engine_sva.sv
module npacc_engine_sva #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_wr_en,
    input logic              hst_rd_en,
    input logic              hst_rd_valid,
    input logic              hst_rd_retry,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_mabort,
    input logic [DATA_W-1:0] bus_addr,
    input logic [3:0]        bus_cmd,
    input logic [3:0]        bus_be_n,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rd_pend,
    input logic              abort_st
);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req);

    assert_fields_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_cmd)
                                && $stable(bus_be_n) && $stable(bus_wdata));

    assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req);

    assert_launch_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(hst_wr_en));

    assert_retry_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hst_rd_en && rd_pend |=> hst_rd_retry && !hst_rd_valid);

    assert_resp_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_rd_valid && hst_rd_retry));

    assert_resp_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd_valid || hst_rd_retry) |-> $past(hst_rd_en));

    assert_abort_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_mabort |=> abort_st);

endmodule

bind npacc_engine npacc_engine_sva #(.DATA_W(DATA_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .hst_wr_en    (hst_wr_en),
    .hst_rd_en    (hst_rd_en),
    .hst_rd_valid (hst_rd_valid),
    .hst_rd_retry (hst_rd_retry),
    .bus_req      (bus_req),
    .bus_ack      (bus_ack),
    .bus_mabort   (bus_mabort),
    .bus_addr     (bus_addr),
    .bus_cmd      (bus_cmd),
    .bus_be_n     (bus_be_n),
    .bus_wdata    (bus_wdata),
    .rd_pend      (rd_pend_w),
    .abort_st     (abort_st_w)
);

// File: tb/npacc_engine_tb_top.sv
module npacc_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr_en = 1'b0;
    logic        hst_rd_en = 1'b0;
    logic [2:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        hst_rd_valid;
    logic        hst_rd_retry;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic [3:0]  bus_cmd;
    logic [3:0]  bus_be_n;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        bus_mabort = 1'b0;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    npacc_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .hst_wr_en(hst_wr_en), .hst_rd_en(hst_rd_en), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .hst_rd_valid(hst_rd_valid), .hst_rd_retry(hst_rd_retry),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_cmd(bus_cmd),
        .bus_be_n(bus_be_n), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_mabort(bus_mabort)
    );

    function automatic logic [31:0] cfg0(input logic [2:0] fn, input logic [5:0] rg);
        return {21'd0, fn, rg, 2'b00};
    endfunction

    function automatic logic [31:0] cfg1(input logic [7:0] bn, input logic [4:0] dv,
                                         input logic [2:0] fn, input logic [5:0] rg);
        return {8'd0, bn, dv, fn, rg, 2'b01};
    endfunction

    function automatic logic [31:0] cmdword(input logic [3:0] be, input logic [3:0] c);
        return {24'd0, be, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
        hst_wr_en = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr_en = 1'b0; hst_wdata = '0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic v, output logic r,
                           output logic [31:0] d);
        hst_rd_en = 1'b1; hst_addr = a;
        @(negedge clk);
        hst_rd_en = 1'b0;
        v = hst_rd_valid; r = hst_rd_retry; d = hst_rdata;
    endtask

    task automatic rd_expect(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic v, r;
        logic [31:0] d;
        host_rd(a, v, r, d);
        chk(req, {30'd0, v, r}, 32'd2);
        chk(req, d, exp);
    endtask

    task automatic rd_retry(input string req, input logic [2:0] a);
        logic v, r;
        logic [31:0] d;
        host_rd(a, v, r, d);
        chk(req, {30'd0, v, r}, 32'd1);
    endtask

    task automatic do_ack(input logic [31:0] d, input logic ab);
        bus_ack = 1'b1; bus_rdata = d; bus_mabort = ab;
        @(negedge clk);
        bus_ack = 1'b0; bus_rdata = '0; bus_mabort = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] prev_rd;
        logic [31:0] a1;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 bus_req", {31'd0, bus_req}, 32'd0);
        for (int k = 0; k < 5; k++) rd_expect("R12 reset reg", 3'(k), 32'd0);

        // R1 readback, read-only read data, unmapped offset
        host_wr(3'd0, 32'hDEADBEEF);
        host_wr(3'd2, 32'h12345678);
        host_wr(3'd3, 32'hFFFFFFFF);
        host_wr(3'd6, 32'h55555555);
        rd_expect("R1 addr", 3'd0, 32'hDEADBEEF);
        rd_expect("R1 wdata", 3'd2, 32'h12345678);
        rd_expect("R1 rdata ro", 3'd3, 32'd0);
        rd_expect("R1 unmapped", 3'd6, 32'd0);

        // Type 1 configuration read: R3 R11 R6 R5 R2
        a1 = cfg1(8'h5A, 5'd17, 3'd2, 6'd9);
        host_wr(3'd0, a1);
        host_wr(3'd1, 32'hFFFFFF0A);
        chk("R3 req", {31'd0, bus_req}, 32'd1);
        chk("R11 type1 addr", bus_addr, a1);
        chk("R3 cmd", {28'd0, bus_cmd}, 32'hA);
        chk("R3 be", {28'd0, bus_be_n}, 32'h0);
        rd_retry("R6 retry in REQ", 3'd1);
        chk("R4 held", {31'd0, bus_req}, 32'd1);
        do_ack(32'hCAFEF00D, 1'b0);
        chk("R4 drop", {31'd0, bus_req}, 32'd0);
        rd_retry("R6 retry in FILL", 3'd3);
        rd_expect("R5 rdata", 3'd3, 32'hCAFEF00D);
        rd_expect("R2 cmd upper zero", 3'd1, 32'h0000000A);
        rd_expect("R8 idle status", 3'd4, 32'd0);

        // Type 0 configuration write with a dropped command: R11 R7 R8 R9
        host_wr(3'd0, cfg0(3'd3, 6'h3F));
        host_wr(3'd2, 32'h0000A5A5);
        host_wr(3'd1, cmdword(4'h5, 4'hB));
        chk("R11 type0 addr", bus_addr, cfg0(3'd3, 6'h3F));
        chk("R3 wdata", bus_wdata, 32'h0000A5A5);
        chk("R3 be write", {28'd0, bus_be_n}, 32'h5);
        rd_expect("R7 R8 busy status", 3'd4, 32'h1);
        host_wr(3'd1, cmdword(4'h0, 4'h6));
        chk("R9 bus cmd kept", {28'd0, bus_cmd}, 32'hB);
        rd_expect("R9 cmd reg kept", 3'd1, 32'h5B);
        rd_expect("R9 err set", 3'd4, 32'h3);
        do_ack(32'h0, 1'b0);
        rd_expect("R9 err sticky", 3'd4, 32'h2);
        rd_expect("R5 write leaves rdata", 3'd3, 32'hCAFEF00D);
        host_wr(3'd4, 32'h2);
        rd_expect("R9 err cleared", 3'd4, 32'h0);

        // Aborted memory read: R10
        host_wr(3'd0, 32'h10000000);
        host_wr(3'd1, cmdword(4'h0, 4'h6));
        do_ack(32'h12121212, 1'b1);
        rd_retry("R6 retry abort fill", 3'd4);
        rd_expect("R10 ones", 3'd3, 32'hFFFFFFFF);
        rd_expect("R10 abort set", 3'd4, 32'h4);
        host_wr(3'd4, 32'h4);
        rd_expect("R10 abort cleared", 3'd4, 32'h0);

        // Aborted write: R10 rdata unchanged
        host_wr(3'd3, 32'h0);
        host_wr(3'd1, cmdword(4'h0, 4'h7));
        do_ack(32'h0, 1'b1);
        rd_expect("R10 write abort", 3'd4, 32'h4);
        rd_expect("R10 rdata kept", 3'd3, 32'hFFFFFFFF);
        host_wr(3'd4, 32'h4);
        prev_rd = 32'hFFFFFFFF;

        // Random rounds: R3 R4 R5 R6 R7 R10
        for (int i = 0; i < 40; i++) begin
            logic [31:0] ra, rdw, rv;
            logic [3:0]  rc, rb;
            logic        isrd, ab;
            int          lat, kind;
            ra   = $urandom;
            rdw  = $urandom;
            rv   = $urandom;
            rb   = 4'($urandom);
            kind = $urandom_range(0, 2);
            isrd = 1'($urandom_range(0, 1));
            lat  = $urandom_range(0, 3);
            ab   = ($urandom_range(0, 7) == 0);
            rc   = (kind == 0) ? 4'h2 : (kind == 1) ? 4'h6 : 4'hA;
            rc[0] = ~isrd;
            host_wr(3'd0, ra);
            host_wr(3'd2, rdw);
            host_wr(3'd1, cmdword(rb, rc));
            chk("R3 rnd req", {31'd0, bus_req}, 32'd1);
            chk("R3 rnd addr", bus_addr, ra);
            chk("R5 rnd cmd", {28'd0, bus_cmd}, {28'd0, rc});
            chk("R3 rnd be", {28'd0, bus_be_n}, {28'd0, rb});
            chk("R3 rnd wdata", bus_wdata, rdw);
            for (int j = 0; j < lat; j++) begin
                if (isrd) rd_retry("R6 rnd wait", 3'($urandom_range(0, 4)));
                else      rd_expect("R7 rnd wait", 3'd0, ra);
            end
            chk("R4 rnd held", {31'd0, bus_req}, 32'd1);
            do_ack(rv, ab);
            chk("R4 rnd drop", {31'd0, bus_req}, 32'd0);
            if (isrd) begin
                rd_retry("R6 rnd fill", 3'd3);
                prev_rd = ab ? 32'hFFFFFFFF : rv;
            end
            rd_expect("R5 R10 rnd rdata", 3'd3, prev_rd);
            rd_expect("R10 rnd status", 3'd4, ab ? 32'h4 : 32'h0);
            if (ab) host_wr(3'd4, 32'h4);
        end

        finish_run();
    end

endmodule